// File: doc/BRIEF.md
# Prefixed Operand Instruction Decoder

This block decodes a stream of one-byte instructions for a small stack machine. Each byte carries a 4-bit function code in its upper nibble and a 4-bit data nibble in its lower nibble. Operands wider than four bits are built by sending prefix bytes first. Each prefix folds its nibble into an internal operand register and shifts the result up by four bits. A negative prefix complements the value before the shift, so long negative constants need only a few bytes.

When a non-prefix byte arrives, the block presents the function code and the full-width effective operand one cycle later. For the operate function code, the effective operand is used as an index into a table of secondary operations, and the block reports the operation it selects. Unknown function codes and unknown operation indices are flagged as illegal. An illegal instruction leaves the operand register as it was. The caller supplies one byte per clock with a valid strobe. Fetching, execution and memory access belong to other blocks.

Top module: `pfx_dec_top`

## Requirements
- R1: Bit 7:4 of `in_byte` is the function code and bit 3:0 is the data nibble. The legal codes are 0 jump, 1 load local pointer, 2 positive prefix, 4 load constant, 6 negative prefix, 7 load local, 8 add constant, A conditional jump, C equals constant, D store local and F operate.
- R2: For a non-prefix byte accepted at a clock edge, the next edge raises `out_valid` for one cycle. At that point `out_func` holds the function code and `out_operand` holds the operand register plus the zero-extended data nibble.
- R3: A positive prefix (code 2) loads the operand register with the effective operand shifted left by four bits, with zeros shifted in. It produces no `out_valid`.
- R4: A negative prefix (code 6) loads the operand register with the bitwise complement of the effective operand, shifted left by four bits. It produces no `out_valid`. Operands are two's complement at full width: a negative prefix with nibble 0 followed by load constant 5 yields -11.
- R5: Every legal non-prefix instruction clears the operand register to zero.
- R6: For code F, the effective operand selects a secondary operation, and `out_op` reports it as a code from 1 to 19. The mapping from index to code is: 0x00→1 rev, 0x04→2 diff, 0x05→3 add, 0x07→4 in, 0x08→5 prod, 0x09→6 gt, 0x0B→7 out, 0x0C→8 sub, 0x10→9 seterr, 0x15→10 stopp, 0x1F→11 rem, 0x29→12 testerr, 0x2C→13 div, 0x32→14 not, 0x46→15 and, 0x4B→16 or, 0x52→17 sum, 0x53→18 mul, 0x55→19 stoperr. For any other code, and for any illegal instruction, `out_op` is 0.
- R7: Function codes 3, 5, 9, B and E produce a result with `out_illegal` = 1 and leave the operand register unchanged.
- R8: Code F with an index not listed in R6 produces a result with `out_illegal` = 1 and `out_op` = 0, and leaves the operand register unchanged.
- R9: A new byte is accepted on every cycle that `in_valid` is high, including back to back. While `in_valid` is low, the operand register holds and no result is produced.
- R10: After reset, `out_valid` and `out_illegal` are low, `out_op` is 0 and the operand register is zero.
- R11: The operand register is `W` bits wide, and bits shifted past the top are lost. Seven positive prefixes of nibble F followed by load constant F yield all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` holds an instruction this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | One-cycle strobe for a decoded non-prefix instruction |
| out_func | output | 4 | Function code of the decoded instruction |
| out_operand | output | W | Effective operand, two's complement |
| out_op | output | 5 | Secondary operation code, 0 when none |
| out_illegal | output | 1 | Decoded instruction is illegal |

## Verification
The bench targets prefix chains: a design that cleared the register after a prefix, or that forgot to complement on a negative prefix, would return small positive constants where -11, -32 or all ones are expected. It sends an illegal byte in the middle of a prefix chain. A design that cleared the register on illegal input would lose the pending high nibbles of the next load. It sweeps every operation index, including multi-byte ones such as 0x53, and an out-of-range index built from a negative prefix. A table slip or a narrow index compare would show up as a wrong operation code or as an illegal instruction that goes unreported. Idle gaps between a prefix and its instruction catch a register that fails to hold while `in_valid` is low.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

    localparam logic [3:0] FN_JUMP   = 4'h0;
    localparam logic [3:0] FN_LDPTR  = 4'h1;
    localparam logic [3:0] FN_PFIX   = 4'h2;
    localparam logic [3:0] FN_LDC    = 4'h4;
    localparam logic [3:0] FN_NFIX   = 4'h6;
    localparam logic [3:0] FN_LDLOC  = 4'h7;
    localparam logic [3:0] FN_ADDC   = 4'h8;
    localparam logic [3:0] FN_CJUMP  = 4'hA;
    localparam logic [3:0] FN_EQC    = 4'hC;
    localparam logic [3:0] FN_STLOC  = 4'hD;
    localparam logic [3:0] FN_OPR    = 4'hF;

    localparam int NUM_OPS   = 19;
    localparam int OP_CODE_W = 5;

    // Operation index for output code k+1; the table is sorted by index.
    function automatic logic [7:0] op_index(input int k);
        logic [7:0] r;
        case (k)
            0:       r = 8'h00;
            1:       r = 8'h04;
            2:       r = 8'h05;
            3:       r = 8'h07;
            4:       r = 8'h08;
            5:       r = 8'h09;
            6:       r = 8'h0B;
            7:       r = 8'h0C;
            8:       r = 8'h10;
            9:       r = 8'h15;
            10:      r = 8'h1F;
            11:      r = 8'h29;
            12:      r = 8'h2C;
            13:      r = 8'h32;
            14:      r = 8'h46;
            15:      r = 8'h4B;
            16:      r = 8'h52;
            17:      r = 8'h53;
            default: r = 8'h55;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfx_dec_fdec.sv
module pfx_dec_fdec
    import pfx_dec_pkg::*;
(
    input  logic [3:0] func,
    output logic       is_pfix,
    output logic       is_nfix,
    output logic       is_opr,
    output logic       legal
);

    always_comb begin
        is_pfix = (func == FN_PFIX);
        is_nfix = (func == FN_NFIX);
        is_opr  = (func == FN_OPR);
        case (func)
            FN_JUMP, FN_LDPTR, FN_PFIX, FN_LDC, FN_NFIX, FN_LDLOC,
            FN_ADDC, FN_CJUMP, FN_EQC, FN_STLOC, FN_OPR: legal = 1'b1;
            default:                                     legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfx_dec_operand.sv
module pfx_dec_operand #(
    parameter int W = 32
) (
    input  logic [W-1:0] oreg,
    input  logic [3:0]   nibble,
    output logic [W-1:0] eff,
    output logic [W-1:0] pos_next,
    output logic [W-1:0] neg_next
);

    always_comb begin
        eff      = oreg + W'(nibble);
        pos_next = eff << 4;
        neg_next = (~eff) << 4;
    end

endmodule

// File: rtl/pfx_dec_opsel.sv
module pfx_dec_opsel
    import pfx_dec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]           idx,
    output logic [OP_CODE_W-1:0]   code,
    output logic                   hit
);

    logic [NUM_OPS-1:0] match;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
        assign match[g] = (idx == W'(op_index(g)));
    end

    always_comb begin
        code = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            if (match[k]) code = OP_CODE_W'(k + 1);
        end
        hit = |match;
    end

endmodule

// File: rtl/pfx_dec_top.sv
module pfx_dec_top
    import pfx_dec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 out_valid,
    output logic [3:0]           out_func,
    output logic [W-1:0]         out_operand,
    output logic [OP_CODE_W-1:0] out_op,
    output logic                 out_illegal
);

    initial begin
        assert (W >= 8 && (W % 8) == 0);
    end

    typedef struct packed {
        logic [W-1:0]         oreg;
        logic                 vld;
        logic [3:0]           func;
        logic [W-1:0]         operand;
        logic [OP_CODE_W-1:0] op;
        logic                 illegal;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic                 is_pfix, is_nfix, is_opr, legal;
    logic [W-1:0]         eff, pos_next, neg_next;
    logic [OP_CODE_W-1:0] op_code;
    logic                 op_hit;
    logic                 bad_instr;

    pfx_dec_fdec u_fdec (
        .func    (in_byte[7:4]),
        .is_pfix (is_pfix),
        .is_nfix (is_nfix),
        .is_opr  (is_opr),
        .legal   (legal)
    );

    pfx_dec_operand #(.W(W)) u_operand (
        .oreg     (st_q.oreg),
        .nibble   (in_byte[3:0]),
        .eff      (eff),
        .pos_next (pos_next),
        .neg_next (neg_next)
    );

    pfx_dec_opsel #(.W(W)) u_opsel (
        .idx  (eff),
        .code (op_code),
        .hit  (op_hit)
    );

    assign bad_instr = !legal || (is_opr && !op_hit);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            if (is_pfix) begin
                st_d.oreg = pos_next;
            end else if (is_nfix) begin
                st_d.oreg = neg_next;
            end else begin
                st_d.vld     = 1'b1;
                st_d.func    = in_byte[7:4];
                st_d.operand = eff;
                st_d.illegal = bad_instr;
                st_d.op      = (is_opr && op_hit) ? op_code : '0;
                if (!bad_instr) st_d.oreg = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_func    = st_q.func;
    assign out_operand = st_q.operand;
    assign out_op      = st_q.op;
    assign out_illegal = st_q.illegal;

    a_r3_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_byte[7:4] == FN_PFIX || in_byte[7:4] == FN_NFIX) |=> !out_valid);

    a_r5_clear_after_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_illegal |-> st_q.oreg == '0);

    a_r7_illegal_keeps_oreg: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal |-> st_q.oreg == $past(st_q.oreg));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(st_q.oreg));

    a_r6_op_only_operate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_func != FN_OPR |-> out_op == '0);

    a_r8_illegal_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal |-> out_op == '0);

endmodule

// File: tb/sim_pfx_dec_top.sv
module sim_pfx_dec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [3:0]  out_func;
    logic [31:0] out_operand;
    logic [4:0]  out_op;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfx_dec_top #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_func(out_func), .out_operand(out_operand),
        .out_op(out_op), .out_illegal(out_illegal)
    );

    typedef struct {
        logic [3:0]  fn;
        logic [31:0] opnd;
        logic [4:0]  op;
        logic        ill;
        string       req;
    } exp_t;

    exp_t sb[$];

    function automatic void check(input bit ok, input string req, input string what,
                                  input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endfunction

    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic instr(input logic [3:0] fn, input logic [3:0] nib, input logic [31:0] opnd,
                         input logic [4:0] op, input logic ill, input string req);
        exp_t e;
        e.fn = fn; e.opnd = opnd; e.op = op; e.ill = ill; e.req = req;
        sb.push_back(e);
        put({fn, nib});
    endtask

    // Monitor: compares every produced result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected out_valid", 32'(out_func), 32'hx);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_func == e.fn, e.req, "out_func", 32'(out_func), 32'(e.fn));
                check(out_operand == e.opnd, e.req, "out_operand", out_operand, e.opnd);
                check(out_op == e.op, e.req, "out_op", 32'(out_op), 32'(e.op));
                check(out_illegal == e.ill, e.req, "out_illegal", 32'(out_illegal), 32'(e.ill));
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] tab [19];
        logic [3:0] good_fn [8];
        logic [3:0] bad_fn [5];
        tab = '{8'h00, 8'h04, 8'h05, 8'h07, 8'h08, 8'h09, 8'h0B, 8'h0C, 8'h10, 8'h15,
                8'h1F, 8'h29, 8'h2C, 8'h32, 8'h46, 8'h4B, 8'h52, 8'h53, 8'h55};
        good_fn = '{4'h0, 4'h1, 4'h4, 4'h7, 4'h8, 4'hA, 4'hC, 4'hD};
        bad_fn  = '{4'h3, 4'h5, 4'h9, 4'hB, 4'hE};

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        check(out_valid == 1'b0, "R10", "out_valid", 32'(out_valid), 0);
        check(out_op == 5'd0, "R10", "out_op", 32'(out_op), 0);
        check(out_illegal == 1'b0, "R10", "out_illegal", 32'(out_illegal), 0);
        @(posedge clk);
        #1;

        // R10: register is zero after reset, so the first load sees only its nibble
        instr(4'h4, 4'h7, 32'h7, 5'd0, 1'b0, "R10");
        // R2 and R3: a positive-prefix chain, back to back
        put(8'h21); put(8'h22);
        instr(4'h4, 4'h3, 32'h123, 5'd0, 1'b0, "R3");
        // R5: the register cleared after the load
        instr(4'h4, 4'h0, 32'h0, 5'd0, 1'b0, "R5");
        // R4: negative constants
        put(8'h60);
        instr(4'h4, 4'h5, 32'hFFFF_FFF5, 5'd0, 1'b0, "R4");
        put(8'h61);
        instr(4'h4, 4'h0, 32'hFFFF_FFE0, 5'd0, 1'b0, "R4");
        // R11: full width, top bits dropped
        for (int i = 0; i < 8; i++) put(8'h2F);
        instr(4'h4, 4'hF, 32'hFFFF_FFFF, 5'd0, 1'b0, "R11");
        // R9: idle gap between a prefix and its instruction
        put(8'h21);
        idle(3);
        instr(4'h7, 4'h0, 32'h10, 5'd0, 1'b0, "R9");
        // R6: sweep every operation, with prefixes where needed
        for (int k = 0; k < 19; k++) begin
            if (tab[k] > 8'h0F) put({4'h2, tab[k][7:4]});
            instr(4'hF, tab[k][3:0], 32'(tab[k]), 5'(k + 1), 1'b0, "R6");
        end
        // R8: undefined index with the register holding 0x40, then a load uses the held value
        instr(4'hF, 4'h1, 32'h1, 5'd0, 1'b1, "R8");
        put(8'h24);
        instr(4'hF, 4'hE, 32'h4E, 5'd0, 1'b1, "R8");
        instr(4'h4, 4'h6, 32'h46, 5'd0, 1'b0, "R8");
        // R8: a huge index built by a negative prefix
        put(8'h60);
        instr(4'hF, 4'h0, 32'hFFFF_FFF0, 5'd0, 1'b1, "R8");
        instr(4'h4, 4'h1, 32'hFFFF_FFF1, 5'd0, 1'b0, "R8");
        // R7: illegal code in the middle of a chain keeps the register
        put(8'h21);
        instr(4'h3, 4'h7, 32'h17, 5'd0, 1'b1, "R7");
        instr(4'h4, 4'h2, 32'h12, 5'd0, 1'b0, "R7");
        // R1: every legal non-prefix code, then every illegal code
        for (int i = 0; i < 8; i++) instr(good_fn[i], 4'h3, 32'h3, 5'd0, 1'b0, "R1");
        for (int i = 0; i < 5; i++) instr(bad_fn[i], 4'h2, 32'h2, 5'd0, 1'b1, "R7");
        idle(4);

        check(sb.size() == 0, "R2", "results missing", 32'(sb.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule